// File: doc/BRIEF.md
# Self-Recovering Decade Counter

This block is a four-bit synchronous decade counter. On each rising clock edge with the count enable high, it steps through the decimal digits zero to nine and then returns to zero. Its next state comes from a fixed set of exclusive-OR equations, one per state bit. These equations send every one of the six non-decimal codes back into the decimal sequence within two enabled clocks. A corrupted register therefore recovers without any outside help.

A combinational error flag marks every non-decimal code. A carry output lets a following decade stage use it as its own count enable. A synchronous reset has priority over all other inputs. A test-only load port lets a bench place the register in any of the sixteen codes, including the illegal ones.

Top module: `bcd_ctr`

## Requirements
- R1: While `rst` is high at a rising clock edge, the digit becomes 0000 on that edge, whatever `tstLoad` and `cntEn` are.
- R2: With `rst`, `tstLoad` and `cntEn` all low, the digit holds its value across a clock edge.
- R3: With `cntEn` high (and `rst`, `tstLoad` low), a legal digit d becomes (d+1) mod 10 on the edge, so 1001 is followed by 0000.
- R4: `carryOut` is high exactly when the digit is 1001 and `cntEn` is high; it is low at any other digit, and low at 1001 when `cntEn` is low.
- R5: `errFlag` is high exactly when the digit is one of 1010 through 1111, which means bit 3 is set together with bit 2 or bit 1.
- R6: On an enabled count, the even illegal codes 1010, 1100 and 1110 only set bit 0, so they become 1011, 1101 and 1111.
- R7: On an enabled count, the odd illegal codes 1011, 1101 and 1111 become the legal codes 0110, 0100 and 0010. Every illegal code is therefore legal within two enabled clocks.
- R8: With `tstLoad` high and `rst` low, the digit takes the value of `tstData` on the edge, whatever `cntEn` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cntEn | input | 1 | Count enable |
| tstLoad | input | 1 | Test-only load strobe |
| tstData | input | 4 | Value written by the test load |
| digit | output | 4 | Counter state, bit 3 most significant |
| carryOut | output | 1 | Terminal count, for enabling the next decade |
| errFlag | output | 1 | High while the state is a non-decimal code |

## Verification
The counter has no tunable parameters, so the bench builds the single four-bit form. Through the test load port, the bench can reach all sixteen codes. It loads each code, checks the error flag and the carry at that code, and then checks the single enabled step that follows. This puts both halves of every illegal recovery chain within reach. A free-running stretch of more than two full decades is compared against a modulo-ten model.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
  localparam int DigitW = 4;
  localparam logic [DigitW-1:0] LastCode = 4'd9;
  localparam logic [DigitW-1:0] ZeroCode = '0;

  typedef struct packed {
    logic clear;
    logic load;
    logic advance;
  } ctrStrobe_t;
endpackage

// File: rtl/bcd_ctr_ctrl.sv
module bcd_ctr_ctrl
  import bcd_ctr_pkg::*;
(
  input  logic              rst,
  input  logic              cntEn,
  input  logic              tstLoad,
  input  logic [DigitW-1:0] curDigit,
  output ctrStrobe_t        strobe,
  output logic              carryOut
);
  always_comb begin
    strobe.clear   = rst;
    strobe.load    = !rst && tstLoad;
    strobe.advance = !rst && !tstLoad && cntEn;
  end

  assign carryOut = cntEn && (curDigit == LastCode);
endmodule

// File: rtl/bcd_ctr_dp.sv
module bcd_ctr_dp
  import bcd_ctr_pkg::*;
(
  input  logic              clk,
  input  ctrStrobe_t        strobe,
  input  logic [DigitW-1:0] loadVal,
  output logic [DigitW-1:0] curDigit,
  output logic              errFlag
);
  logic [DigitW-1:0] stateQ;
  logic [DigitW-1:0] stepVal;
  logic q1, q2, q4, q8;

  assign {q8, q4, q2, q1} = stateQ;

  always_comb begin
    stepVal[0] = ~q1;
    stepVal[1] = q2 ^ (q1 & ~q8);
    stepVal[2] = q4 ^ (q1 & q2);
    stepVal[3] = q8 ^ ((q1 & q8) | (q1 & q2 & q4));
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)        stateQ <= ZeroCode;
    else if (strobe.load)    stateQ <= loadVal;
    else if (strobe.advance) stateQ <= stepVal;
  end

  assign curDigit = stateQ;
  assign errFlag  = (q8 & q4) | (q8 & q2);
endmodule

// File: rtl/bcd_ctr.sv
module bcd_ctr
  import bcd_ctr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cntEn,
  input  logic              tstLoad,
  input  logic [DigitW-1:0] tstData,
  output logic [DigitW-1:0] digit,
  output logic              carryOut,
  output logic              errFlag
);
  ctrStrobe_t strobe;

  bcd_ctr_ctrl u_ctrl (
    .rst(rst), .cntEn(cntEn), .tstLoad(tstLoad),
    .curDigit(digit), .strobe(strobe), .carryOut(carryOut)
  );

  bcd_ctr_dp u_dp (
    .clk(clk), .strobe(strobe), .loadVal(tstData),
    .curDigit(digit), .errFlag(errFlag)
  );
endmodule

// File: rtl/bcd_ctr_chk.sv
module bcd_ctr_chk
  import bcd_ctr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cntEn,
  input logic              tstLoad,
  input logic [DigitW-1:0] tstData,
  input logic [DigitW-1:0] digit,
  input logic              carryOut,
  input logic              errFlag
);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tstLoad && !cntEn) |=> $stable(digit));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!tstLoad && cntEn && digit == 4'd9) |=> (digit == 4'd0));

  p_carry_r4: assert property (@(posedge clk) disable iff (rst)
    carryOut |-> (cntEn && digit == 4'd9));

  p_err_r5: assert property (@(posedge clk) disable iff (rst)
    errFlag == (digit > 4'd9));

  p_even_bad_r6: assert property (@(posedge clk) disable iff (rst)
    (!tstLoad && cntEn && errFlag && !digit[0]) |=> (digit[0] && $past(digit[3:1]) == digit[3:1]));

  p_odd_bad_r7: assert property (@(posedge clk) disable iff (rst)
    (!tstLoad && cntEn && errFlag && digit[0]) |=> !errFlag);

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    tstLoad |=> (digit == $past(tstData)));
endmodule

bind bcd_ctr bcd_ctr_chk u_chk (
  .clk(clk), .rst(rst), .cntEn(cntEn), .tstLoad(tstLoad), .tstData(tstData),
  .digit(digit), .carryOut(carryOut), .errFlag(errFlag)
);

// File: tb/sim_bcd_ctr.sv
module sim_bcd_ctr;
  logic clk = 0;
  logic rst = 1;
  logic cntEn = 0;
  logic tstLoad = 0;
  logic [3:0] tstData = 0;
  logic [3:0] digit;
  logic carryOut, errFlag;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bcd_ctr u0 (
    .clk(clk), .rst(rst), .cntEn(cntEn), .tstLoad(tstLoad), .tstData(tstData),
    .digit(digit), .carryOut(carryOut), .errFlag(errFlag)
  );

  // each entry: {code, expected next on enabled count, expected error flag}
  localparam logic [8:0] VEC [16] = '{
    {4'd0,  4'd1, 1'b0}, {4'd1,  4'd2, 1'b0}, {4'd2,  4'd3, 1'b0}, {4'd3,  4'd4, 1'b0},
    {4'd4,  4'd5, 1'b0}, {4'd5,  4'd6, 1'b0}, {4'd6,  4'd7, 1'b0}, {4'd7,  4'd8, 1'b0},
    {4'd8,  4'd9, 1'b0}, {4'd9,  4'd0, 1'b0}, {4'd10, 4'd11, 1'b1}, {4'd11, 4'd6, 1'b1},
    {4'd12, 4'd13, 1'b1}, {4'd13, 4'd4, 1'b1}, {4'd14, 4'd15, 1'b1}, {4'd15, 4'd2, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic loadCode(input logic [3:0] c);
    tstLoad = 1; tstData = c;
    tick();
    tstLoad = 0;
    #1;
  endtask

  initial begin
    logic [3:0] model;
    tick();
    tick();
    check("R1 reset digit", digit, 0);
    rst = 0;
    #1;
    check("R4 carry low after reset", carryOut, 0);

    // table walk: load each code, check flags, step once
    for (int i = 0; i < 16; i++) begin
      logic [3:0] code, nxt;
      logic er;
      {code, nxt, er} = VEC[i];
      cntEn = 0;
      loadCode(code);
      check("R8 load", digit, code);
      check("R5 error flag", errFlag, er);
      cntEn = 1;
      #1;
      check("R4 carry enabled", carryOut, (code == 4'd9) ? 1 : 0);
      tick();
      if (code > 4'd9 && !code[0]) check("R6 even illegal step", digit, nxt);
      else if (code > 4'd9)        check("R7 odd illegal step", digit, nxt);
      else                         check("R3 legal step", digit, nxt);
    end

    // R7: two-clock recovery from each even illegal code
    for (int c = 10; c < 16; c += 2) begin
      cntEn = 0;
      loadCode(4'(c));
      cntEn = 1;
      tick();
      tick();
      check("R7 legal within two clocks", errFlag, 0);
    end

    // R3 free run against modulo-10 model
    cntEn = 0;
    loadCode(4'd0);
    model = 0;
    cntEn = 1;
    for (int k = 0; k < 25; k++) begin
      tick();
      model = (model == 4'd9) ? 4'd0 : model + 4'd1;
      check("R3 free run", digit, model);
    end

    // R2 hold
    cntEn = 0;
    loadCode(4'd9);
    check("R4 carry low when disabled", carryOut, 0);
    tick(); tick();
    check("R2 hold", digit, 9);
    loadCode(4'd12);
    tick();
    check("R2 hold illegal", digit, 12);

    // R8 load over enable
    cntEn = 1;
    loadCode(4'd5);
    check("R8 load beats enable", digit, 5);

    // R1 reset priority over load and enable
    rst = 1; tstLoad = 1; tstData = 4'd7; cntEn = 1;
    tick();
    check("R1 reset priority", digit, 0);
    rst = 0; tstLoad = 0;
    done = 1;
  end

  initial begin
    for (int w = 0; w < 5000 && !done; w++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    #20;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule